// File: doc/BRIEF.md
# Double-Buffered Serial Receiver/Transmitter with Test Clocking

This block is an asynchronous serial transmitter and receiver. Each direction has a holding register and a shift register, so a new character can wait while the previous one is still on the line. Transmit and receive run independently and can be busy at the same moment. A six-bit frame word sets the frame layout: the character length (five to eight data bits), whether a parity bit is present, whether parity is even or odd, and whether one or two stop bits are sent.

Every serial bit lasts sixteen ticks of a bit clock. A four-bit rate selector picks the tick source. A non-zero value divides the system clock by `BASE_DIV` times the selector value. The value zero selects an external clock. In test-clocking mode, software supplies that external clock one pulse at a time: each high-to-low transition of a reference bit gives one tick. This lets a test step the transmitter and receiver bit by bit when the serial output is looped back to the input.

The receiver flags a ready character, parity errors, break frames and overruns. It also exposes the synchronized serial input line for test.

Top module: `uart_dbuf`

## Requirements
- R1: The data length is 5 plus `frame_word[1:0]`. Data is sent least significant bit first. A received character sits in the low bits of `rx_data`, and the unused upper bits read zero.
- R2: When `frame_word[3]` is set, a parity bit follows the data bits. `frame_word[2]` set selects even parity and clear selects odd parity. The receiver raises `rx_parity_err` when the received parity bit does not match the data.
- R3: `frame_word[5]` set sends two stop bits and clear sends one. Back-to-back frames therefore start every (2 + data bits + parity bit + extra stop bit) × 16 ticks.
- R4: Each serial bit lasts 16 ticks. With `rate_sel` non-zero, one tick occurs every `BASE_DIV*rate_sel` clock cycles.
- R5: With `rate_sel` zero and `diag_mode` high, each high-to-low transition of `diag_ref` gives exactly one tick. With `rate_sel` zero and `diag_mode` low, no ticks occur and the serial state does not move.
- R6: A pulse on `tx_load` fills the transmit holding register, and `tx_hold_empty` falls. The character moves to the shift register once the shift register is idle. A load while the holding register is full is dropped. `tx_idle` is high only when both transmit registers are empty.
- R7: A completed frame sets `rx_ready` and updates `rx_data`. A pulse on `rx_take` clears `rx_ready`.
- R8: A frame that completes while `rx_ready` is still set raises `rx_overrun`. The newer character replaces the held one. `rx_take` clears `rx_overrun`.
- R9: A frame received entirely as zero, including its stop bit, sets `rx_break` and delivers a zero character.
- R10: The receiver samples each bit at mid-bit. A start bit that is no longer low at its mid-bit sample is rejected, and the receiver returns to idle without delivering a character.
- R11: `rx_line` shows the serial input after `SYNC_STAGES` clock cycles of synchronization.
- R12: After reset, `serial_out` and `rx_line` are high, `tx_hold_empty` and `tx_idle` are high, and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_word | input | 6 | [1:0] length-5, [2] even parity, [3] parity on, [5] two stop bits, [4] unused |
| rate_sel | input | 4 | Tick rate; 0 selects the external clock |
| diag_mode | input | 1 | Test-clocking mode enable |
| diag_ref | input | 1 | Reference bit; a falling edge is one tick in test-clocking mode |
| tx_data | input | 8 | Character to transmit |
| tx_load | input | 1 | Write `tx_data` to the transmit holding register |
| tx_hold_empty | output | 1 | Transmit holding register can accept a character |
| tx_idle | output | 1 | Both transmit registers are empty |
| serial_out | output | 1 | Serial transmit line, high when idle |
| serial_in | input | 1 | Serial receive line |
| rx_line | output | 1 | Synchronized receive line, for test |
| rx_data | output | 8 | Received character |
| rx_ready | output | 1 | A received character is waiting |
| rx_take | input | 1 | Acknowledge the waiting character |
| rx_parity_err | output | 1 | Parity mismatch on the last character |
| rx_break | output | 1 | The last frame was all zero |
| rx_overrun | output | 1 | A character was replaced before it was taken |

## Verification
The bench builds the block with `BASE_DIV=2` and `SYNC_STAGES=2`. At rate 1 a serial bit is then only 32 clock cycles, so full frames, back-to-back frame spacing, overrun and break all fit in a short run. Rate 3 stretches the bit to 96 cycles, which checks the divider scaling. Test-clocking mode is stepped with sixteen hand-made reference pulses per bit, so the exact tick on which a bit boundary falls can be observed.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;

   localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop

   typedef struct packed {
      logic       two_stop;
      logic       par_en;
      logic       par_even;
      logic [1:0] size;
   } frame_cfg_t;

   function automatic frame_cfg_t decode_frame(input logic [5:0] w);
      frame_cfg_t c;
      c.two_stop = w[5];
      c.par_en   = w[3];
      c.par_even = w[2];
      c.size     = w[1:0];
      return c;
   endfunction

   function automatic logic [3:0] data_len(input logic [1:0] size);
      return 4'd5 + {2'b00, size};
   endfunction

   function automatic logic [3:0] frame_len(input frame_cfg_t c);
      return 4'd2 + data_len(c.size) + {3'b000, c.par_en} + {3'b000, c.two_stop};
   endfunction

   function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] size);
      logic [7:0] m;
      m = 8'hFF >> (2'd3 - size);
      return d & m;
   endfunction

   function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
      logic p;
      p = ^mask_data(d, c.size);
      return c.par_even ? p : ~p;
   endfunction

   function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input frame_cfg_t c);
      logic [FRAME_W-1:0] f;
      logic [3:0]         n;
      f    = '1;
      f[0] = 1'b0;
      n    = data_len(c.size);
      for (int i = 0; i < 8; i++) begin
         if (i < int'(n)) f[i+1] = d[i];
      end
      if (c.par_en) f[n + 4'd1] = parity_of(d, c);
      return f;
   endfunction

endpackage

// File: rtl/udb_tick_gen.sv
module udb_tick_gen #(
   parameter int BASE_DIV = 16,
   parameter int RATE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              diag_mode,
   input  logic              diag_ref,
   output logic              tick
);
   localparam int MAX_PERIOD = BASE_DIV * ((1 << RATE_W) - 1);
   localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period;
   logic             ref_q;
   logic             int_tick;
   logic             ext_tick;
   logic             ext_sel;

   always_comb begin
      ext_sel  = (rate_sel == '0);
      period   = CNT_W'(BASE_DIV * int'(rate_sel));
      int_tick = !ext_sel && (cnt_q >= period - CNT_W'(1));
      ext_tick = ext_sel && diag_mode && ref_q && !diag_ref;
      tick     = int_tick | ext_tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ref_q <= 1'b0;
      end else begin
         ref_q <= diag_ref;
         if (ext_sel || int_tick) cnt_q <= '0;
         else                     cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R5
   no_ext_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == '0 && !diag_mode) |-> !tick);

   // R4
   int_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_tick && BASE_DIV > 1) |=> !int_tick);

endmodule

// File: rtl/udb_tx.sv
module udb_tx
   import uart_dbuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_cfg_t cfg,
   input  logic       load,
   input  logic [7:0] data,
   output logic       hold_empty,
   output logic       idle,
   output logic       line
);
   logic               hold_full;
   logic [7:0]         hold_q;
   logic               busy;
   logic [FRAME_W-1:0] sh_q;
   logic [3:0]         left_q;
   logic [3:0]         phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
         busy      <= 1'b0;
         sh_q      <= '1;
         left_q    <= '0;
         phase_q   <= '0;
      end else begin
         if (load && !hold_full) begin
            hold_q    <= data;
            hold_full <= 1'b1;
         end
         if (!busy && hold_full) begin
            sh_q      <= build_frame(hold_q, cfg);
            left_q    <= frame_len(cfg);
            phase_q   <= '0;
            busy      <= 1'b1;
            hold_full <= 1'b0;
         end else if (busy && tick) begin
            if (phase_q == 4'd15) begin
               phase_q <= '0;
               sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
               left_q  <= left_q - 4'd1;
               if (left_q == 4'd1) busy <= 1'b0;
            end else begin
               phase_q <= phase_q + 4'd1;
            end
         end
      end
   end

   assign hold_empty = !hold_full;
   assign idle       = !hold_full && !busy;
   assign line       = busy ? sh_q[0] : 1'b1;

   // R6
   drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && hold_full && busy) |=> $stable(hold_q));

   // R4
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(line));

endmodule

// File: rtl/udb_rx.sv
module udb_rx
   import uart_dbuf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_cfg_t cfg,
   input  logic       line_s,
   input  logic       take,
   output logic [7:0] data,
   output logic       ready,
   output logic       perr,
   output logic       brk,
   output logic       ovr
);
   logic       active;
   logic [3:0] phase_q;
   logic [3:0] idx_q;
   logic [7:0] sh_q;
   logic       pbit_q;
   logic       zero_q;
   frame_cfg_t cfg_q;
   logic [3:0] n_bits;
   logic [3:0] last_idx;
   logic       at_mid;
   logic       done;

   always_comb begin
      n_bits   = data_len(cfg_q.size);
      last_idx = n_bits + {3'b000, cfg_q.par_en} + 4'd1;
      at_mid   = active && tick && (phase_q == 4'd8);
      done     = at_mid && (idx_q == last_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         phase_q <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         pbit_q  <= 1'b0;
         zero_q  <= 1'b0;
         cfg_q   <= '0;
         data    <= '0;
         ready   <= 1'b0;
         perr    <= 1'b0;
         brk     <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (take) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
         end
         if (!active) begin
            if (tick && !line_s) begin
               active  <= 1'b1;
               phase_q <= 4'd1;
               idx_q   <= '0;
               sh_q    <= '0;
               zero_q  <= 1'b1;
               cfg_q   <= cfg;
            end
         end else if (tick) begin
            phase_q <= phase_q + 4'd1;
            if (phase_q == 4'd8) begin
               idx_q  <= idx_q + 4'd1;
               zero_q <= zero_q & ~line_s;
               if (idx_q == 4'd0) begin
                  if (line_s) active <= 1'b0;
               end else if (idx_q <= n_bits) begin
                  sh_q[3'(idx_q - 4'd1)] <= line_s;
               end else if (cfg_q.par_en && idx_q == n_bits + 4'd1) begin
                  pbit_q <= line_s;
               end
               if (idx_q == last_idx) begin
                  active <= 1'b0;
                  data   <= sh_q;
                  ready  <= 1'b1;
                  ovr    <= (ovr | ready) & ~take;
                  perr   <= cfg_q.par_en & (pbit_q != parity_of(sh_q, cfg_q));
                  brk    <= zero_q & ~line_s;
               end
            end
         end
      end
   end

   // R7
   take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !done) |=> !ready);

   // R8
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ready && !take) |=> ovr);

   // R9
   brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> (data == 8'h00));

endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
   import uart_dbuf_pkg::*;
#(
   parameter int BASE_DIV    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [5:0] frame_word,
   input  logic [3:0] rate_sel,
   input  logic       diag_mode,
   input  logic       diag_ref,
   input  logic [7:0] tx_data,
   input  logic       tx_load,
   output logic       tx_hold_empty,
   output logic       tx_idle,
   output logic       serial_out,
   input  logic       serial_in,
   output logic       rx_line,
   output logic [7:0] rx_data,
   output logic       rx_ready,
   input  logic       rx_take,
   output logic       rx_parity_err,
   output logic       rx_break,
   output logic       rx_overrun
);
   if (BASE_DIV < 1) begin : g_bad_div
      $error("BASE_DIV must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   frame_cfg_t cfg;
   logic       tick;
   logic       line_s;

   assign cfg = decode_frame(frame_word);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = serial_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= '1;
         else        st_q <= SYNC_STAGES'({st_q, serial_in});
      end
      assign line_s = st_q[SYNC_STAGES-1];
   end

   assign rx_line = line_s;

   udb_tick_gen #(.BASE_DIV(BASE_DIV), .RATE_W(4)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .diag_mode(diag_mode),
      .diag_ref (diag_ref),
      .tick     (tick)
   );

   udb_tx u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cfg       (cfg),
      .load      (tx_load),
      .data      (tx_data),
      .hold_empty(tx_hold_empty),
      .idle      (tx_idle),
      .line      (serial_out)
   );

   udb_rx u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .cfg   (cfg),
      .line_s(line_s),
      .take  (rx_take),
      .data  (rx_data),
      .ready (rx_ready),
      .perr  (rx_parity_err),
      .brk   (rx_break),
      .ovr   (rx_overrun)
   );

endmodule

// File: tb/uart_dbuf_bench.sv
module uart_dbuf_bench;
   localparam int BASE_DIV = 2;
   localparam int BIT      = 16 * BASE_DIV;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] frame_word;
   logic [3:0] rate_sel;
   logic       diag_mode, diag_ref;
   logic [7:0] tx_data;
   logic       tx_load, tx_hold_empty, tx_idle, serial_out, serial_in;
   logic       rx_line, rx_ready, rx_take, rx_parity_err, rx_break, rx_overrun;
   logic [7:0] rx_data;
   logic       lb_en, drv_line;

   int  total = 0;
   int  bad   = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   assign serial_in = lb_en ? serial_out : drv_line;

   uart_dbuf #(.BASE_DIV(BASE_DIV), .SYNC_STAGES(2)) u_uart_dbuf (
      .clk(clk), .rst_n(rst_n), .frame_word(frame_word), .rate_sel(rate_sel),
      .diag_mode(diag_mode), .diag_ref(diag_ref), .tx_data(tx_data), .tx_load(tx_load),
      .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle), .serial_out(serial_out),
      .serial_in(serial_in), .rx_line(rx_line), .rx_data(rx_data), .rx_ready(rx_ready),
      .rx_take(rx_take), .rx_parity_err(rx_parity_err), .rx_break(rx_break),
      .rx_overrun(rx_overrun)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clks(3);
      rst_n = 1'b1;
      clks(2);
   endtask

   task automatic load(input logic [7:0] d);
      tx_data = d;
      tx_load = 1'b1;
      clks(1);
      tx_load = 1'b0;
   endtask

   task automatic take();
      rx_take = 1'b1;
      clks(1);
      rx_take = 1'b0;
   endtask

   task automatic pulse_ref();
      diag_ref = 1'b1;
      clks(2);
      diag_ref = 1'b0;
      clks(2);
   endtask

   task automatic wait_fall();
      for (int i = 0; i < 4000; i++) begin
         if (serial_out == 1'b0) return;
         clks(1);
      end
   endtask

   task automatic decode_tx(input int n, input bit pen, output logic [7:0] d, output logic p);
      wait_fall();
      clks(BIT / 2);
      d = '0;
      p = 1'b0;
      for (int i = 0; i < n; i++) begin
         clks(BIT);
         d[i] = serial_out;
      end
      if (pen) begin
         clks(BIT);
         p = serial_out;
      end
   endtask

   task automatic drive_frame(input logic [7:0] d, input int n, input bit pen,
                              input logic pbit, input int nstop);
      drv_line = 1'b0;
      clks(BIT);
      for (int i = 0; i < n; i++) begin
         drv_line = d[i];
         clks(BIT);
      end
      if (pen) begin
         drv_line = pbit;
         clks(BIT);
      end
      drv_line = 1'b1;
      clks(BIT * nstop);
   endtask

   task automatic t_reset();
      do_reset();
      check(serial_out == 1'b1, "R12 serial_out", serial_out, 1);
      check(tx_idle == 1'b1 && tx_hold_empty == 1'b1, "R12 tx empty",
            {tx_idle, tx_hold_empty}, 3);
      check(rx_ready == 1'b0, "R12 rx_ready", rx_ready, 0);
      check(rx_line == 1'b1, "R12 rx_line", rx_line, 1);
   endtask

   task automatic t_loop_basic();
      lb_en = 1'b1;
      frame_word = 6'b000011;
      tx_data = 8'hA5;
      tx_load = 1'b1;
      clks(1);
      tx_load = 1'b0;
      check(tx_hold_empty == 1'b0, "R6 hold filled", tx_hold_empty, 0);
      clks(1);
      check(tx_hold_empty == 1'b1 && tx_idle == 1'b0, "R6 moved to shifter",
            {tx_hold_empty, tx_idle}, 2);
      clks(360);
      check(rx_ready == 1'b1, "R7 ready", rx_ready, 1);
      check(rx_data == 8'hA5, "R7 data", rx_data, 8'hA5);
      check(rx_parity_err == 1'b0 && rx_break == 1'b0, "R7 no errors",
            {rx_parity_err, rx_break}, 0);
      check(tx_idle == 1'b1, "R6 idle after frame", tx_idle, 1);
      take();
      check(rx_ready == 1'b0, "R7 take clears", rx_ready, 0);
   endtask

   task automatic t_size5();
      logic [7:0] d;
      logic       p;
      lb_en = 1'b1;
      frame_word = 6'b000000;
      load(8'hFF);
      decode_tx(5, 1'b0, d, p);
      check(d == 8'h1F, "R1 five tx bits", d, 8'h1F);
      clks(100);
      check(rx_ready == 1'b1 && rx_data == 8'h1F, "R1 five rx bits", rx_data, 8'h1F);
      take();
   endtask

   task automatic t_parity();
      logic [7:0] d;
      logic       p;
      lb_en = 1'b1;
      frame_word = 6'b001111;
      load(8'h03);
      decode_tx(8, 1'b1, d, p);
      check(d == 8'h03 && p == 1'b0, "R2 even parity bit", {d, p}, 9'h006);
      clks(100);
      check(rx_ready == 1'b1 && rx_parity_err == 1'b0, "R2 even rx ok",
            {rx_ready, rx_parity_err}, 2);
      take();
      frame_word = 6'b001011;
      load(8'h03);
      decode_tx(8, 1'b1, d, p);
      check(p == 1'b1, "R2 odd parity bit", p, 1);
      clks(100);
      check(rx_ready == 1'b1 && rx_parity_err == 1'b0, "R2 odd rx ok",
            {rx_ready, rx_parity_err}, 2);
      take();
      lb_en = 1'b0;
      frame_word = 6'b001111;
      drive_frame(8'h03, 8, 1'b1, 1'b1, 1);
      clks(20);
      check(rx_ready == 1'b1 && rx_parity_err == 1'b1, "R2 bad parity flagged",
            {rx_ready, rx_parity_err}, 3);
      check(rx_data == 8'h03, "R2 data with bad parity", rx_data, 8'h03);
      take();
   endtask

   task automatic gap_run(input logic [5:0] fw, input logic [7:0] b, input int nbits,
                          input logic [7:0] bmask, input string tag);
      int  cnt;
      logic prev;
      lb_en = 1'b1;
      frame_word = fw;
      load(8'h00);
      wait_fall();
      cnt = 0;
      load(b);
      cnt++;
      load(8'h77);
      cnt++;
      prev = serial_out;
      for (int i = 0; i < 1000; i++) begin
         clks(1);
         cnt++;
         if (prev == 1'b1 && serial_out == 1'b0) break;
         prev = serial_out;
      end
      check(cnt >= 32 * nbits && cnt <= 32 * nbits + 2, tag, cnt, 32 * nbits);
      clks(360);
      check(rx_ready == 1'b1 && rx_overrun == 1'b1, "R8 overrun set",
            {rx_ready, rx_overrun}, 3);
      check(rx_data == (b & bmask), "R8 R6 newest kept, full load dropped",
            rx_data, b & bmask);
      take();
      check(rx_ready == 1'b0 && rx_overrun == 1'b0, "R8 take clears overrun",
            {rx_ready, rx_overrun}, 0);
   endtask

   task automatic t_stop();
      gap_run(6'b101010, 8'h5A, 11, 8'h7F, "R3 two stop spacing");
      gap_run(6'b000011, 8'h81, 10, 8'hFF, "R3 one stop spacing");
   endtask

   task automatic t_rate();
      int cnt;
      lb_en = 1'b0;
      frame_word = 6'b000011;
      rate_sel = 4'd3;
      load(8'h01);
      wait_fall();
      cnt = 0;
      for (int i = 0; i < 400; i++) begin
         if (serial_out == 1'b1) break;
         clks(1);
         cnt++;
      end
      check(cnt >= 91 && cnt <= 96, "R4 start bit length at rate 3", cnt, 96);
      clks(1000);
      rate_sel = 4'd1;
      clks(4);
   endtask

   task automatic t_diag();
      lb_en = 1'b0;
      frame_word = 6'b000011;
      rate_sel = 4'd0;
      diag_mode = 1'b1;
      diag_ref = 1'b0;
      clks(2);
      load(8'h55);
      clks(3);
      check(serial_out == 1'b0, "R5 start bit out", serial_out, 0);
      repeat (15) pulse_ref();
      check(serial_out == 1'b0, "R5 still start after 15 pulses", serial_out, 0);
      pulse_ref();
      check(serial_out == 1'b1, "R5 bit0 after 16 pulses", serial_out, 1);
      diag_mode = 1'b0;
      repeat (20) pulse_ref();
      check(serial_out == 1'b1, "R5 no ticks outside test mode", serial_out, 1);
      rate_sel = 4'd1;
      do_reset();
   endtask

   task automatic t_break();
      lb_en = 1'b0;
      frame_word = 6'b000011;
      drv_line = 1'b0;
      clks(320);
      check(rx_ready == 1'b1 && rx_break == 1'b1, "R9 break flagged",
            {rx_ready, rx_break}, 3);
      check(rx_data == 8'h00, "R9 zero char", rx_data, 0);
      drv_line = 1'b1;
      do_reset();
   endtask

   task automatic t_glitch();
      lb_en = 1'b0;
      frame_word = 6'b000011;
      drv_line = 1'b0;
      clks(8);
      drv_line = 1'b1;
      clks(64);
      check(rx_ready == 1'b0, "R10 short start rejected", rx_ready, 0);
      drive_frame(8'h3C, 8, 1'b0, 1'b0, 1);
      clks(20);
      check(rx_ready == 1'b1 && rx_data == 8'h3C, "R10 next frame received",
            rx_data, 8'h3C);
      take();
   endtask

   task automatic t_line();
      lb_en = 1'b0;
      drv_line = 1'b0;
      clks(3);
      check(rx_line == 1'b0, "R11 line low visible", rx_line, 0);
      drv_line = 1'b1;
      clks(3);
      check(rx_line == 1'b1, "R11 line high visible", rx_line, 1);
      clks(64);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      frame_word = 6'b000011;
      rate_sel = 4'd1;
      diag_mode = 1'b0;
      diag_ref = 1'b0;
      tx_data = '0;
      tx_load = 1'b0;
      rx_take = 1'b0;
      lb_en = 1'b0;
      drv_line = 1'b1;
      t_reset();
      t_loop_basic();
      t_size5();
      t_parity();
      t_stop();
      t_rate();
      t_diag();
      t_break();
      t_glitch();
      t_line();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule